// File: doc/BRIEF.md
# Windowed Integer Register File

This block is the integer register storage of a processor that uses overlapping register windows. Instructions name 32 architectural registers. The upper two bits of a register number pick one of four eight-entry frames: globals, outs, locals and ins. The lower three bits pick the entry inside that frame. A window-pointer input selects which physical segments back the outs, locals and ins. The segments form a ring of twice as many entries as there are windows, so the ins of one window and the outs of the neighbouring window are the same storage. A separate flag swaps the ordinary globals for a second, alternate global set.

The block has two combinational read ports and one write port that writes on the rising clock edge. Each read port also returns the flattened physical index that the register number resolved to. A synchronous clear input empties every physical entry. Moving the window pointer changes only how later register numbers are translated; stored values stay where they are.

Top module: `wrf_regfile`

## Requirements
- R1: The 3-bit offset of a register number (bits 2:0) always appears unchanged in bits 2:0 of the physical index, and every physical index is below 16 + 16×NWINDOWS.
- R2: Frame 0 (register number bits 4:3 = 0) maps to physical index 0..7 when `alt_glob` is 0 and to 8..15 when `alt_glob` is 1.
- R3: With the reduced pointer w and base b = ((NWINDOWS − w) mod NWINDOWS)×2, frame 1 maps to segment b, frame 2 to segment b+1 and frame 3 to segment (b+2) mod 2×NWINDOWS, where segment s occupies physical indices 16+8s..16+8s+7.
- R4: A value written through frame 3 with window pointer w reads back through frame 1 with window pointer (w−1) mod NWINDOWS, including the wrap from w = 0 to w = NWINDOWS−1.
- R5: Changing `cwp` or `alt_glob` never alters stored data: returning to the earlier setting reads the earlier values.
- R6: A cycle with `clear` high zeroes every physical entry of both global sets and all segments, and a write requested in that same cycle is dropped.
- R7: Register number 0 with `alt_glob` 0 always reads zero and writes to it are ignored; register number 0 with `alt_glob` 1 is an ordinary storage entry.
- R8: Reads are combinational from the present `cwp`, `alt_glob` and index; a write takes effect at the rising edge, using the `cwp` and `alt_glob` values present in that cycle, and is visible on the read ports right after that edge.
- R9: A `cwp` value at or above NWINDOWS is treated as `cwp` mod NWINDOWS.
- R10: A clock edge with `rst_n` low clears all storage.
- R11: The two read ports translate and read independently of each other in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset, clears storage |
| clear | input | 1 | Synchronous clear of all storage |
| cwp | input | CWP_W | Current window pointer |
| alt_glob | input | 1 | Select the alternate global set for frame 0 |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Architectural register number to write |
| wr_data | input | DATA_W | Write data |
| rd_a_idx | input | 5 | Architectural register number, read port A |
| rd_a_data | output | DATA_W | Read data, port A |
| rd_a_phys | output | PIDX_W | Flattened physical index, port A |
| rd_b_idx | input | 5 | Architectural register number, read port B |
| rd_b_data | output | DATA_W | Read data, port B |
| rd_b_phys | output | PIDX_W | Flattened physical index, port B |

## Verification
Physical indices and read data are combinational, so they are due in the same cycle as the index, pointer and flag that produce them. The bench applies those inputs one time unit after a rising edge and samples a time unit later, well before the next edge. A write, clear or reset is due one edge later. The bench holds the request across exactly one rising edge and samples one time unit after it. It also checks read data before that edge, to show that a pending write is not yet visible.

// File: rtl/wrf_pkg.sv
// Package: shared constants and the frame encoding of the windowed register file.
// Assumes a 5-bit architectural register number split into 2 frame bits
// and 3 offset bits.
package wrf_pkg;

    localparam int ARCH_IDX_W = 5;
    localparam int OFF_W      = 3;
    localparam int FRAME_REGS = 1 << OFF_W;
    localparam int GLOB_BASE  = 0;
    localparam int ALTG_BASE  = FRAME_REGS;
    localparam int SEG_BASE   = 2 * FRAME_REGS;

    typedef enum logic [1:0] {
        FR_GLOBAL = 2'd0,
        FR_OUT    = 2'd1,
        FR_LOCAL  = 2'd2,
        FR_IN     = 2'd3
    } frame_e;

endpackage

// File: rtl/wrf_map.sv
// Module: wrf_map
// Translates one architectural register number into a flattened physical
// index, using the window pointer and the alternate-globals flag.
// Assumes NWINDOWS in 3..32; a pointer at or above NWINDOWS is reduced
// modulo NWINDOWS. Purely combinational.
module wrf_map
    import wrf_pkg::*;
#(
    parameter int NWINDOWS = 6,
    parameter int CWP_W    = 3,
    parameter int PIDX_W   = 7
) (
    input  logic [CWP_W-1:0]      cwp,
    input  logic                  alt_glob,
    input  logic [ARCH_IDX_W-1:0] idx,
    output logic [PIDX_W-1:0]     phys
);

    localparam int NSEG = 2 * NWINDOWS;

    frame_e           frame;
    logic [OFF_W-1:0] offset;
    int unsigned      win;
    int unsigned      seg_base;
    int unsigned      seg;
    int unsigned      frame_base;

    // Split the register number into frame and offset.
    always_comb begin
        frame  = frame_e'(idx[ARCH_IDX_W-1:OFF_W]);
        offset = idx[OFF_W-1:0];
    end

    // Reduce the pointer and find the outs segment of this window.
    always_comb begin
        win      = int'(unsigned'(cwp)) % NWINDOWS;
        seg_base = ((NWINDOWS - win) % NWINDOWS) * 2;
    end

    // Pick the base offset of the addressed frame.
    always_comb begin
        seg = 0;
        frame_base = GLOB_BASE;
        unique case (frame)
            FR_GLOBAL: frame_base = alt_glob ? ALTG_BASE : GLOB_BASE;
            FR_OUT: begin
                seg        = seg_base;
                frame_base = SEG_BASE + seg * FRAME_REGS;
            end
            FR_LOCAL: begin
                seg        = seg_base + 1;
                frame_base = SEG_BASE + seg * FRAME_REGS;
            end
            FR_IN: begin
                seg        = (seg_base + 2) % NSEG;
                frame_base = SEG_BASE + seg * FRAME_REGS;
            end
            default: frame_base = GLOB_BASE;
        endcase
    end

    // Bases are eight-aligned, so the offset fills the low bits.
    always_comb begin
        phys = PIDX_W'(frame_base) | PIDX_W'(offset);
    end

endmodule

// File: rtl/wrf_store.sv
// Module: wrf_store
// Flat physical storage: one write port, two combinational read ports.
// Entry 0 is the hardwired-zero register and is never written.
// Assumes synchronous active-low reset; clear and reset both zero every
// entry and override a write in the same cycle.
module wrf_store #(
    parameter int DATA_W = 32,
    parameter int NPHYS  = 112,
    parameter int PIDX_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              we,
    input  logic [PIDX_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [PIDX_W-1:0] raddr_a,
    output logic [DATA_W-1:0] rdata_a,
    input  logic [PIDX_W-1:0] raddr_b,
    output logic [DATA_W-1:0] rdata_b
);

    logic [DATA_W-1:0] mem [NPHYS];

    // Clear everything on reset or clear, else write one non-zero entry.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NPHYS; i++) begin
            if (!rst_n || clear) begin
                mem[i] <= '0;
            end else if (we && (waddr == PIDX_W'(i)) && (i != 0)) begin
                mem[i] <= wdata;
            end
        end
    end

    // Read mux for port A.
    always_comb begin
        rdata_a = '0;
        for (int i = 0; i < NPHYS; i++) begin
            if (raddr_a == PIDX_W'(i)) rdata_a = mem[i];
        end
    end

    // Read mux for port B.
    always_comb begin
        rdata_b = '0;
        for (int i = 0; i < NPHYS; i++) begin
            if (raddr_b == PIDX_W'(i)) rdata_b = mem[i];
        end
    end

endmodule

// File: rtl/wrf_regfile.sv
// Module: wrf_regfile (top)
// Windowed integer register file: 32 architectural numbers mapped onto
// two global sets and 2*NWINDOWS circular segments of eight entries.
// Assumes NWINDOWS in 3..32. Three identical translators serve the write
// port and both read ports, so all use the same-cycle cwp and flag.
module wrf_regfile
    import wrf_pkg::*;
#(
    parameter int NWINDOWS = 6,
    parameter int DATA_W   = 32,
    parameter int CWP_W    = $clog2(NWINDOWS),
    parameter int PIDX_W   = $clog2(SEG_BASE + 2 * NWINDOWS * FRAME_REGS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear,
    input  logic [CWP_W-1:0]      cwp,
    input  logic                  alt_glob,
    input  logic                  wr_en,
    input  logic [ARCH_IDX_W-1:0] wr_idx,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic [ARCH_IDX_W-1:0] rd_a_idx,
    output logic [DATA_W-1:0]     rd_a_data,
    output logic [PIDX_W-1:0]     rd_a_phys,
    input  logic [ARCH_IDX_W-1:0] rd_b_idx,
    output logic [DATA_W-1:0]     rd_b_data,
    output logic [PIDX_W-1:0]     rd_b_phys
);

    localparam int NPHYS  = SEG_BASE + 2 * NWINDOWS * FRAME_REGS;
    localparam int NPORTS = 3;
    localparam int P_WR   = 0;
    localparam int P_RA   = 1;
    localparam int P_RB   = 2;

    logic [ARCH_IDX_W-1:0] port_idx  [NPORTS];
    logic [PIDX_W-1:0]     port_phys [NPORTS];

    // Gather the register numbers of every port.
    always_comb begin
        port_idx[P_WR] = wr_idx;
        port_idx[P_RA] = rd_a_idx;
        port_idx[P_RB] = rd_b_idx;
    end

    for (genvar p = 0; p < NPORTS; p++) begin : g_map
        wrf_map #(
            .NWINDOWS (NWINDOWS),
            .CWP_W    (CWP_W),
            .PIDX_W   (PIDX_W)
        ) u_map (
            .cwp      (cwp),
            .alt_glob (alt_glob),
            .idx      (port_idx[p]),
            .phys     (port_phys[p])
        );
    end

    wrf_store #(
        .DATA_W (DATA_W),
        .NPHYS  (NPHYS),
        .PIDX_W (PIDX_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear),
        .we      (wr_en),
        .waddr   (port_phys[P_WR]),
        .wdata   (wr_data),
        .raddr_a (port_phys[P_RA]),
        .rdata_a (rd_a_data),
        .raddr_b (port_phys[P_RB]),
        .rdata_b (rd_b_data)
    );

    // Drive the physical index outputs.
    always_comb begin
        rd_a_phys = port_phys[P_RA];
        rd_b_phys = port_phys[P_RB];
    end

endmodule

// File: rtl/wrf_checker.sv
// Module: wrf_checker
// Port-level properties of wrf_regfile, attached with a bind.
// Assumes the same parameters as the top module.
module wrf_checker #(
    parameter int NWINDOWS = 6,
    parameter int DATA_W   = 32,
    parameter int CWP_W    = 3,
    parameter int PIDX_W   = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clear,
    input logic [CWP_W-1:0]  cwp,
    input logic              alt_glob,
    input logic              wr_en,
    input logic [4:0]        wr_idx,
    input logic [DATA_W-1:0] wr_data,
    input logic [4:0]        rd_a_idx,
    input logic [DATA_W-1:0] rd_a_data,
    input logic [PIDX_W-1:0] rd_a_phys,
    input logic [4:0]        rd_b_idx,
    input logic [DATA_W-1:0] rd_b_data,
    input logic [PIDX_W-1:0] rd_b_phys
);

    localparam int NPHYS = 16 + 16 * NWINDOWS;

    // R1: offset bits pass through and the index stays in range.
    p_offset_kept_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_phys[2:0] == rd_a_idx[2:0]) && (int'(rd_a_phys) < NPHYS)
        && (int'(rd_b_phys) < NPHYS));

    // R2: frame 0 lands in the global set chosen by the flag.
    p_global_map_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_idx[4:3] == 2'd0) |->
        ((int'(rd_a_phys) < 16) && (rd_a_phys[3] == alt_glob)));

    // R3: windowed frames land in the segment area.
    p_window_area_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_b_idx[4:3] != 2'd0) |-> (int'(rd_b_phys) >= 16));

    // R7: the hardwired zero register reads zero.
    p_zero_reg_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_a_idx == 5'd0) && !alt_glob) |-> (rd_a_data == '0));

    // R6: after a clear cycle both ports read zero.
    p_clear_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> ((rd_a_data == '0) && (rd_b_data == '0)));

    // R8: a write is visible next cycle at the same mapping.
    p_write_seen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clear && (rd_a_idx == wr_idx)
         && ((wr_idx != 5'd0) || alt_glob))
        |=> (!($stable(cwp) && $stable(alt_glob) && $stable(rd_a_idx))
             || (rd_a_data == $past(wr_data))));

endmodule

bind wrf_regfile wrf_checker #(
    .NWINDOWS (NWINDOWS),
    .DATA_W   (DATA_W),
    .CWP_W    (CWP_W),
    .PIDX_W   (PIDX_W)
) u_chk (.*);

// File: tb/wrf_regfile_tb.sv
module wrf_regfile_tb;

    localparam int CLK_P    = 10;
    localparam int NW       = 6;
    localparam int DW       = 32;
    localparam int CW       = 3;
    localparam int PW       = 7;
    localparam int NVEC     = 14;

    // Vector fields: cwp[15:13] alt[12] idx[11:7] expected phys[6:0]
    localparam logic [15:0] VEC [NVEC] = '{
        {3'd0, 1'b0, 5'd3,  7'd3},   // R2 normal globals
        {3'd0, 1'b1, 5'd3,  7'd11},  // R2 alternate globals
        {3'd0, 1'b1, 5'd0,  7'd8},   // R2 alternate reg 0
        {3'd0, 1'b0, 5'd8,  7'd16},  // R3 outs, seg 0
        {3'd0, 1'b0, 5'd17, 7'd25},  // R3 locals, seg 1
        {3'd0, 1'b0, 5'd26, 7'd34},  // R3 ins, seg 2
        {3'd1, 1'b0, 5'd8,  7'd96},  // R3 outs, seg 10
        {3'd1, 1'b0, 5'd23, 7'd111}, // R3 locals, seg 11
        {3'd1, 1'b0, 5'd24, 7'd16},  // R3 ins wrap to seg 0
        {3'd3, 1'b0, 5'd12, 7'd68},  // R3 outs, seg 6
        {3'd5, 1'b0, 5'd31, 7'd55},  // R3 ins, seg 4
        {3'd6, 1'b0, 5'd8,  7'd16},  // R9 cwp 6 acts as 0
        {3'd7, 1'b0, 5'd9,  7'd97},  // R9 cwp 7 acts as 1
        {3'd2, 1'b1, 5'd7,  7'd15}   // R2 alt globals ignore cwp
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clear = 1'b0;
    logic [CW-1:0] cwp = '0;
    logic          alt_glob = 1'b0;
    logic          wr_en = 1'b0;
    logic [4:0]    wr_idx = '0;
    logic [DW-1:0] wr_data = '0;
    logic [4:0]    rd_a_idx = '0;
    logic [DW-1:0] rd_a_data;
    logic [PW-1:0] rd_a_phys;
    logic [4:0]    rd_b_idx = '0;
    logic [DW-1:0] rd_b_data;
    logic [PW-1:0] rd_b_phys;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    wrf_regfile #(.NWINDOWS(NW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .clear(clear), .cwp(cwp),
        .alt_glob(alt_glob), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_a_phys(rd_a_phys), .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .rd_b_phys(rd_b_phys)
    );

    task automatic chk(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Hold a write across one rising edge, then sample 1 unit later.
    task automatic do_write(input logic [2:0] w, input logic a,
                            input logic [4:0] i, input logic [31:0] d);
        cwp = w; alt_glob = a; wr_idx = i; wr_data = d; wr_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd_a(input logic [2:0] w, input logic a,
                        input logic [4:0] i);
        cwp = w; alt_glob = a; rd_a_idx = i; #1;
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;

        // R10: storage empty after reset
        rd_a(3'd0, 1'b0, 5'd8);  chk("R10 reset outs", rd_a_data, 0);
        rd_a(3'd4, 1'b1, 5'd5);  chk("R10 reset alt", rd_a_data, 0);

        // R1 R2 R3 R9 R11: table of mappings on both ports
        for (int v = 0; v < NVEC; v++) begin
            cwp = VEC[v][15:13]; alt_glob = VEC[v][12];
            rd_a_idx = VEC[v][11:7];
            rd_b_idx = VEC[(v + 1) % NVEC][11:7];
            #1;
            chk("R3 mapping port A", 32'(rd_a_phys), 32'(VEC[v][6:0]));
            if (VEC[(v + 1) % NVEC][15:12] == VEC[v][15:12])
                chk("R11 mapping port B", 32'(rd_b_phys),
                    32'(VEC[(v + 1) % NVEC][6:0]));
            chk("R1 offset", 32'(rd_a_phys[2:0]), 32'(VEC[v][9:7]));
        end

        // R8: write not visible before the edge, visible right after
        cwp = 3'd2; alt_glob = 1'b0; rd_a_idx = 5'd16;
        wr_idx = 5'd16; wr_data = 32'hA5A5_0001; wr_en = 1'b1; #1;
        chk("R8 before edge", rd_a_data, 0);
        @(posedge clk); #1; wr_en = 1'b0;
        chk("R8 after edge", rd_a_data, 32'hA5A5_0001);

        // R8: write uses same-cycle cwp (cwp 3 locals = seg 7, phys 72)
        do_write(3'd3, 1'b0, 5'd16, 32'h0000_0777);
        rd_a(3'd2, 1'b0, 5'd16); chk("R8 cwp2 kept", rd_a_data, 32'hA5A5_0001);
        rd_a(3'd3, 1'b0, 5'd16); chk("R8 cwp3 data", rd_a_data, 32'h0000_0777);

        // R4: ins of window 3 are outs of window 2
        do_write(3'd3, 1'b0, 5'd25, 32'hCAFE_0003);
        rd_a(3'd2, 1'b0, 5'd9);  chk("R4 alias", rd_a_data, 32'hCAFE_0003);
        // R4: wrap, ins of window 0 are outs of window 5
        do_write(3'd0, 1'b0, 5'd31, 32'hBEEF_0005);
        rd_a(3'd5, 1'b0, 5'd15); chk("R4 wrap", rd_a_data, 32'hBEEF_0005);

        // R7: reg 0 of normal globals ignores writes; alternate reg 0 holds
        do_write(3'd0, 1'b0, 5'd0, 32'hFFFF_FFFF);
        rd_a(3'd0, 1'b0, 5'd0);  chk("R7 zero reg", rd_a_data, 0);
        do_write(3'd0, 1'b1, 5'd0, 32'h1234_5678);
        rd_a(3'd0, 1'b1, 5'd0);  chk("R7 alt reg0", rd_a_data, 32'h1234_5678);
        do_write(3'd1, 1'b0, 5'd4, 32'h0000_0044);
        do_write(3'd1, 1'b1, 5'd4, 32'h0000_0088);

        // R5 R11: after pointer and flag moves, data is where it was
        rd_a(3'd4, 1'b1, 5'd4);
        rd_b_idx = 5'd25; cwp = 3'd3; #1;
        chk("R5 alt g4 kept", rd_a_data, 32'h0000_0088);
        chk("R11 port B ins", rd_b_data, 32'hCAFE_0003);
        rd_a(3'd5, 1'b0, 5'd4);  chk("R5 g4 kept", rd_a_data, 32'h0000_0044);
        rd_a(3'd2, 1'b0, 5'd16); chk("R5 locals kept", rd_a_data, 32'hA5A5_0001);

        // R6: clear wins over a same-cycle write and empties everything
        cwp = 3'd1; alt_glob = 1'b0; wr_idx = 5'd10; wr_data = 32'h5555_5555;
        wr_en = 1'b1; clear = 1'b1;
        @(posedge clk); #1; wr_en = 1'b0; clear = 1'b0;
        for (int w = 0; w < NW; w++) begin
            for (int a = 0; a < 2; a++) begin
                for (int i = 0; i < 32; i++) begin
                    rd_a(3'(w), 1'(a), 5'(i));
                    chk("R6 cleared", rd_a_data, 0);
                end
            end
        end

        // R10: a later reset also clears storage
        do_write(3'd2, 1'b0, 5'd20, 32'h0BAD_F00D);
        rd_a(3'd2, 1'b0, 5'd20); chk("R10 pre", rd_a_data, 32'h0BAD_F00D);
        rst_n = 1'b0; @(posedge clk); #1; rst_n = 1'b1;
        rd_a(3'd2, 1'b0, 5'd20); chk("R10 after reset", rd_a_data, 0);

        done = 1'b1;
        summary();
    end

endmodule